// File: doc/BRIEF.md
# I2C Target Address Filter

This block is the receive/transmit front end of an I2C target. It samples the open-drain SCL and SDA lines in the system clock domain, recognises bus conditions, shifts address and data bytes in and out, and decides whether to acknowledge. The own address is a 10-bit input. A mode input chooses whether the target answers to its low 7 bits or to the full 10-bit address. The mode and own address are expected to change only while the bus is idle.

Write bytes are passed to the register side as one-cycle strobes. Read bytes are taken from a byte the register side keeps presented, and a strobe tells it when that byte has been consumed. When a full 10-bit write addressing has been seen, the block keeps that match across a repeated START. A following read that carries only the first address byte is then answered. A STOP discards the match.

Top module: `i2c_tgt_addr_filter`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a STOP the block releases SDA (sda_oe = 0) and answers nothing until the next START. Out of reset sda_oe, wr_valid and rd_take are 0.
- R2: In 7-bit mode (ten_bit_mode = 0) the first byte after a START carries the address in bits 7:1 and the direction in bit 0, where 1 means read. If bits 7:1 equal own_addr[6:0], SDA is held low for the ninth clock. Otherwise it stays released, and the rest of the transfer is not acknowledged.
- R3: After a matching write address, every further byte is received MSB first and acknowledged. Its value appears on wr_data with a one-cycle wr_valid pulse, once per byte.
- R4: After a matching read address, the block sends bytes MSB first. Each byte is the value on rd_data when rd_take pulses for one cycle, just after the SCL fall that precedes the byte's first bit.
- R5: When the master acknowledges a sent byte (SDA low on the ninth clock), the next byte follows. When it does not acknowledge, SDA stays released, no further rd_take occurs, and the bus reads all ones until a START or STOP.
- R6: In 10-bit mode a first byte of 11110, own_addr[9:8] and 0 is acknowledged. The second byte is acknowledged only if it equals own_addr[7:0], and it then enables data writes as in R3.
- R7: In 10-bit mode, after a full write match, a repeated START followed by the single byte 11110, own_addr[9:8], 1 is acknowledged and starts a read as in R4. After a failed second byte the same short read is not acknowledged.
- R8: In 10-bit mode a first byte that does not begin with 11110, or whose bits 2:1 differ from own_addr[9:8], is not acknowledged.
- R9: A STOP clears the 10-bit match, so a later START with only the short read byte is not acknowledged.
- R10: A repeated START (after an acknowledge, with no STOP) restarts address reception, so a write may be followed by a read of the same target in one transfer.
- R11: The block changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 10 | Own target address; 7-bit mode uses bits 6:0 |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_data | output | 8 | Received write byte |
| rd_data | input | 8 | Byte offered for the next read |
| rd_take | output | 1 | One-cycle strobe: rd_data was loaded for sending |

## Verification
A wrong bit count or phase shows up at the ninth clock of the same byte. The acknowledge either goes missing, or it lands on a data bit that the master samples as a corrupted value. A stale or missing 10-bit match is visible only one transfer later, as the acknowledge of a short read after a repeated START or after a STOP. For that reason the scenarios pair each addressing sequence with a following short read. A misfiring read strobe changes which byte values reach the master on the next byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_TXLOAD, ST_WAIT
   } tgt_state_e;

   typedef enum logic [1:0] {
      PH_ADDR1, PH_ADDR2, PH_WDATA, PH_READ
   } phase_e;

   typedef struct packed {
      logic   ack;
      phase_e nxt;
      logic   set_hit;
      logic   clr_hit;
   } match_res_t;

   localparam logic [4:0] TEN_PREFIX = 5'b11110;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   initial begin
      if (STAGES < 2) $fatal(1, "i2c_tgt_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b1;
      else        chain[0] <= d;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[g] <= 1'b1;
         else        chain[g] <= chain[g-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_tgt_events.sv
module i2c_tgt_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match
   import i2c_tgt_pkg::*;
#(
   parameter bit TEN_BIT_EN = 1'b1
) (
   input  phase_e     ph,
   input  logic [7:0] byte_i,
   input  logic [9:0] own_addr,
   input  logic       ten_bit_mode,
   input  logic       ten_hit,
   output match_res_t res
);
   logic ten_on;

   if (TEN_BIT_EN) begin : g_ten
      assign ten_on = ten_bit_mode;
   end else begin : g_seven
      assign ten_on = ten_bit_mode & 1'b0;
   end

   logic pfx_ok, hi_ok;
   assign pfx_ok = (byte_i[7:3] == TEN_PREFIX);
   assign hi_ok  = (byte_i[2:1] == own_addr[9:8]);

   always_comb begin
      res = '{ack: 1'b0, nxt: PH_ADDR1, set_hit: 1'b0, clr_hit: 1'b0};
      case (ph)
         PH_ADDR1: begin
            if (ten_on) begin
               if (pfx_ok && hi_ok) begin
                  if (!byte_i[0]) begin
                     res.ack     = 1'b1;
                     res.nxt     = PH_ADDR2;
                     res.clr_hit = 1'b1;
                  end else if (ten_hit) begin
                     res.ack = 1'b1;
                     res.nxt = PH_READ;
                  end
               end
            end else if (byte_i[7:1] == own_addr[6:0]) begin
               res.ack     = 1'b1;
               res.nxt     = byte_i[0] ? PH_READ : PH_WDATA;
               res.clr_hit = 1'b1;
            end
         end
         PH_ADDR2: begin
            if (byte_i == own_addr[7:0]) begin
               res.ack     = 1'b1;
               res.nxt     = PH_WDATA;
               res.set_hit = 1'b1;
            end else begin
               res.clr_hit = 1'b1;
            end
         end
         PH_WDATA: begin
            res.ack = 1'b1;
            res.nxt = PH_WDATA;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/i2c_tgt_addr_filter.sv
module i2c_tgt_addr_filter
   import i2c_tgt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit TEN_BIT_EN  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [9:0] own_addr,
   input  logic       ten_bit_mode,
   output logic       wr_valid,
   output logic [7:0] wr_data,
   input  logic [7:0] rd_data,
   output logic       rd_take
);
   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   logic scl_lvl, sda_lvl;
   logic scl_rise, scl_fall, start_ev, stop_ev;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_lvl));
   i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_lvl));

   i2c_tgt_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_lvl), .sda_s(sda_lvl),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev));

   tgt_state_e       state;
   phase_e           ph, nxt_ph;
   logic [CNT_W-1:0] bitcnt;
   logic [7:0]       shreg;
   logic             ten_hit;
   match_res_t       mres;

   i2c_tgt_match #(.TEN_BIT_EN(TEN_BIT_EN)) u_match (
      .ph(ph), .byte_i(shreg), .own_addr(own_addr),
      .ten_bit_mode(ten_bit_mode), .ten_hit(ten_hit), .res(mres));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ph       <= PH_ADDR1;
         nxt_ph   <= PH_ADDR1;
         bitcnt   <= '0;
         shreg    <= '0;
         ten_hit  <= 1'b0;
         sda_oe   <= 1'b0;
         wr_valid <= 1'b0;
         wr_data  <= '0;
         rd_take  <= 1'b0;
      end else begin
         wr_valid <= 1'b0;
         rd_take  <= 1'b0;
         if (stop_ev) begin
            state   <= ST_IDLE;
            ten_hit <= 1'b0;
            sda_oe  <= 1'b0;
         end else if (start_ev) begin
            state  <= ST_RX;
            ph     <= PH_ADDR1;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise && bitcnt < LAST_BIT) begin
                     shreg  <= {shreg[6:0], sda_lvl};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == LAST_BIT) begin
                     if (mres.set_hit)      ten_hit <= 1'b1;
                     else if (mres.clr_hit) ten_hit <= 1'b0;
                     if (mres.ack) begin
                        sda_oe <= 1'b1;
                        nxt_ph <= mres.nxt;
                        state  <= ST_ACK;
                        if (ph == PH_WDATA) begin
                           wr_valid <= 1'b1;
                           wr_data  <= shreg;
                        end
                     end else begin
                        state <= ST_WAIT;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (nxt_ph == PH_READ) begin
                        shreg   <= rd_data;
                        sda_oe  <= ~rd_data[7];
                        rd_take <= 1'b1;
                        state   <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        ph     <= nxt_ph;
                        state  <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bitcnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        state  <= ST_TXACK;
                     end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                     end
                  end
               end
               ST_TXACK: begin
                  if (scl_rise) state <= sda_lvl ? ST_WAIT : ST_TXLOAD;
               end
               ST_TXLOAD: begin
                  if (scl_fall) begin
                     shreg   <= rd_data;
                     sda_oe  <= ~rd_data[7];
                     rd_take <= 1'b1;
                     bitcnt  <= '0;
                     state   <= ST_TX;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_lvl,
   input logic       start_ev,
   input logic       stop_ev,
   input logic       sda_oe,
   input logic       ten_hit,
   input logic       wr_valid,
   input logic       rd_take,
   input logic [7:0] rd_data
);
   assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_lvl);

   assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (!sda_oe && !ten_hit));

   assert_restart_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> !sda_oe);

   assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_valid, rd_take}));

   assert_first_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_take |-> (sda_oe == !$past(rd_data[7])));
endmodule

bind i2c_tgt_addr_filter i2c_tgt_checker chk_i (
   .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_ev(start_ev),
   .stop_ev(stop_ev), .sda_oe(sda_oe), .ten_hit(ten_hit),
   .wr_valid(wr_valid), .rd_take(rd_take), .rd_data(rd_data));

// File: tb/i2c_tgt_addr_filter_tb_top.sv
module i2c_tgt_addr_filter_tb_top;
   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       scl_m, sda_m, sda_bus;
   logic       sda_oe, ten_bit_mode, wr_valid, rd_take;
   logic [9:0] own_addr;
   logic [7:0] wr_data, rd_data;
   int         total = 0, bad = 0, rd_idx, exp_rd = 0;
   logic [7:0] wq[$];

   always #4 clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;

   function automatic logic [7:0] rd_val(input int k);
      return 8'(k * 37) ^ 8'hA5;
   endfunction
   assign rd_data = rd_val(rd_idx);

   always @(posedge clk or negedge rst_n)
      if (!rst_n) rd_idx <= 0;
      else if (rd_take) rd_idx <= rd_idx + 1;

   i2c_tgt_addr_filter dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
      .own_addr(own_addr), .ten_bit_mode(ten_bit_mode), .wr_valid(wr_valid),
      .wr_data(wr_data), .rd_data(rd_data), .rd_take(rd_take));

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor for write bytes (R3)
   always @(negedge clk) begin
      logic [7:0] e;
      if (rst_n && wr_valid) begin
         total++;
         if (wq.size() == 0) begin
            bad++;
            $display("FAIL R3 unexpected write byte actual=%h expected=none", wr_data);
         end else begin
            e = wq.pop_front();
            if (e != wr_data) begin
               bad++;
               $display("FAIL R3 write byte actual=%h expected=%h", wr_data, e);
            end
         end
      end
   end

   task automatic q_wait; repeat (Q) @(negedge clk); endtask

   task automatic clk_bit(input bit b, output bit s);
      sda_m = b; q_wait;
      scl_m = 1'b1; q_wait;
      s = sda_bus; q_wait;
      scl_m = 1'b0; q_wait;
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      bit s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      ack = !s;
   endtask

   task automatic send_data(input logic [7:0] b, input bit expect_ack, input string req);
      bit a;
      if (expect_ack) wq.push_back(b);
      send_byte(b, a);
      chk(a == expect_ack, req, 16'(a), 16'(expect_ack));
   endtask

   task automatic read_byte(input bit mack, output logic [7:0] v);
      bit s;
      for (int i = 0; i < 8; i++) begin
         clk_bit(1'b1, s);
         v = {v[6:0], s};
      end
      clk_bit(!mack, s);
   endtask

   task automatic read_chk(input bit mack, input string req);
      logic [7:0] v, e;
      e = rd_val(exp_rd);
      read_byte(mack, v);
      exp_rd++;
      chk(v == e, req, 16'(v), 16'(e));
   endtask

   task automatic start_c; sda_m = 1'b0; q_wait; scl_m = 1'b0; q_wait; endtask
   task automatic rstart_c;
      sda_m = 1'b1; q_wait; scl_m = 1'b1; q_wait;
      sda_m = 1'b0; q_wait; scl_m = 1'b0; q_wait;
   endtask
   task automatic stop_c;
      sda_m = 1'b0; q_wait; scl_m = 1'b1; q_wait;
      sda_m = 1'b1; q_wait; q_wait;
      chk(sda_oe == 1'b0, "R1 released after stop", 16'(sda_oe), 16'h0);
   endtask

   task automatic addr(input logic [7:0] b, input bit expect_ack, input string req);
      bit a;
      send_byte(b, a);
      chk(a == expect_ack, req, 16'(a), 16'(expect_ack));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
      own_addr = 10'h2B5; ten_bit_mode = 1'b0;
      repeat (5) @(negedge clk);
      chk(sda_oe == 0 && wr_valid == 0 && rd_take == 0, "R1 reset state",
          16'({sda_oe, wr_valid, rd_take}), 16'h0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      own_addr = 10'h042;

      // R2/R3: 7-bit write
      start_c;
      addr({7'h42, 1'b0}, 1'b1, "R2 7-bit write match");
      send_data(8'h3C, 1'b1, "R3 write byte ack");
      send_data(8'hC3, 1'b1, "R3 write byte ack");
      stop_c;

      // R2: other address ignored
      start_c;
      addr({7'h43, 1'b0}, 1'b0, "R2 7-bit mismatch nack");
      send_data(8'h99, 1'b0, "R2 no ack after mismatch");
      stop_c;

      // R4/R5: 7-bit read
      start_c;
      addr({7'h42, 1'b1}, 1'b1, "R4 7-bit read match");
      read_chk(1'b1, "R4 read byte 0");
      read_chk(1'b0, "R5 read byte after master ack");
      read_byte(1'b0, v);
      chk(v == 8'hFF, "R5 silent after nack", 16'(v), 16'hFF);
      chk(rd_idx == exp_rd, "R5 no strobe after nack", 16'(rd_idx), 16'(exp_rd));
      stop_c;

      // R10: write then repeated START read
      start_c;
      addr({7'h42, 1'b0}, 1'b1, "R10 write address");
      send_data(8'h5A, 1'b1, "R10 write byte");
      rstart_c;
      addr({7'h42, 1'b1}, 1'b1, "R10 read after repeated start");
      read_chk(1'b0, "R10 read byte");
      stop_c;

      // 10-bit mode, own address 0x2B5
      own_addr = 10'h2B5; ten_bit_mode = 1'b1;
      repeat (4) @(negedge clk);
      start_c;
      addr(8'hF4, 1'b1, "R6 10-bit first byte");
      addr(8'hB5, 1'b1, "R6 10-bit second byte");
      send_data(8'h11, 1'b1, "R6 10-bit write byte");
      rstart_c;
      addr(8'hF5, 1'b1, "R7 short read after match");
      read_chk(1'b1, "R7 read byte 0");
      read_chk(1'b0, "R7 read byte 1");
      stop_c;

      start_c;
      addr(8'hF4, 1'b1, "R6 10-bit first byte");
      addr(8'hB6, 1'b0, "R6 wrong second byte nack");
      rstart_c;
      addr(8'hF5, 1'b0, "R7 short read after failed match");
      stop_c;

      start_c;
      addr(8'hF6, 1'b0, "R8 high bits mismatch");
      stop_c;
      start_c;
      addr(8'h6A, 1'b0, "R8 non-prefix byte in 10-bit mode");
      stop_c;

      // R9: full match, STOP, then short read
      start_c;
      addr(8'hF4, 1'b1, "R9 setup first byte");
      addr(8'hB5, 1'b1, "R9 setup second byte");
      stop_c;
      start_c;
      addr(8'hF5, 1'b0, "R9 short read after stop");
      stop_c;

      chk(wq.size() == 0, "R3 all write bytes seen", 16'(wq.size()), 16'h0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule